// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block works out the addresses for data accesses and keeps the pointers that walk through memory. It holds a small file of buffer contexts. Each context has a pointer, a start address, a ring length and a bit-reverse field width. A request selects a context, an addressing mode, pre- or post-modify, an access size and a signed modifier. The block returns the effective address and the new pointer value one clock later. It writes the new pointer back at the same edge, so the next request can use it.

In indirect mode a context with a nonzero length acts as a ring buffer. The ring may start at any address, and the pointer folds back into the ring without software help. A context with length zero steps linearly. Bit-reverse mode reverses the low bits of the pointer across a programmable field width and adds the start address, which gives transform-ordered access. Immediate mode passes the modifier through as the address. A configuration port loads the context fields. A stall input freezes all state.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, `out_valid` is 0 and every context field (pointer, start, length, reverse width) is 0.
- R2: An accepted request (`req_valid` high, `stall` low) gives `out_valid` high with its results exactly one cycle later. A request in the next cycle on the same context sees the pointer that the previous request produced.
- R3: Post-modify (`req_pre`=0) in indirect or bit-reverse mode addresses from the pointer value held before the update.
- R4: Pre-modify (`req_pre`=1) in indirect mode returns the updated pointer as the address.
- R5: The modifier is scaled by the access size before use: `req_size` 0 gives ×1 (single), 1 gives ×2 (dual), 2 gives ×4 (quad).
- R6: In indirect mode with length L≠0, if pointer+step ≥ start+L, the new pointer is pointer+step−L. This holds for step magnitudes up to L.
- R7: In indirect mode with L≠0, if pointer+step < start, the new pointer is pointer+step+L. The start address needs no alignment.
- R8: In indirect mode with L=0, the new pointer is pointer+step, taken modulo 2^AW.
- R9: In bit-reverse mode (`req_mode`=2), the pointer advances by step with no wrap. The address is start + the reversal of the low W pointer bits across a W-bit field, where W is the context's reverse width. Pre-modify reverses the new pointer and post-modify reverses the old one.
- R10: In immediate mode (`req_mode`=0), the address is the unscaled modifier and the pointer is unchanged. `req_mode`=1 selects indirect and 3 is reserved.
- R11: While `stall` is high, no result is produced and neither requests nor configuration writes change any state.
- R12: A configuration write (`cfg_sel` 0 pointer, 1 start, 2 length, 3 reverse width) changes only the selected field of the selected context. A request changes only its own context's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes all state while high |
| req_valid | input | 1 | Request strobe |
| req_ctx | input | IW | Context index |
| req_mode | input | 2 | 0 immediate, 1 indirect, 2 bit-reverse |
| req_pre | input | 1 | 1 pre-modify, 0 post-modify |
| req_size | input | 2 | 0 single, 1 dual, 2 quad |
| req_mod | input | AW | Signed modifier or immediate address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | IW | Context to program |
| cfg_sel | input | 2 | Field select: 0 pointer, 1 start, 2 length, 3 reverse width |
| cfg_data | input | AW | Value to write |
| out_valid | output | 1 | Result valid |
| out_addr | output | AW | Effective address |
| out_ptr | output | AW | Pointer value after the request |

## Verification
The checks assume that a ring context always holds a pointer inside its ring. They also assume that the scaled step never exceeds the ring length, that start plus length does not overflow the address width, and that the size and mode codes never take the reserved value 3. The stimulus programs each pointer at or inside its ring's start before any use, and it keeps every circular step at or below the ring length, including steps exactly equal to it in both directions. Bit-reverse widths stay well under the address width, and no request and configuration write meet on the same context in the same cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      AM_IMM  = 2'd0,
      AM_IND  = 2'd1,
      AM_BREV = 2'd2,
      AM_RSVD = 2'd3
   } agu_mode_e;

   typedef enum logic [1:0] {
      AS_SINGLE = 2'd0,
      AS_DUAL   = 2'd1,
      AS_QUAD   = 2'd2,
      AS_RSVD   = 2'd3
   } agu_size_e;

   typedef enum logic [1:0] {
      CF_PTR  = 2'd0,
      CF_BASE = 2'd1,
      CF_LEN  = 2'd2,
      CF_BW   = 2'd3
   } agu_cfg_e;

endpackage

// File: rtl/agu_ctx_file.sv
module agu_ctx_file
   import agu_pkg::*;
#(
   parameter int AW   = 32,
   parameter int NCTX = 4,
   parameter int IW   = 2,
   parameter int BWW  = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [IW-1:0]  rd_idx,
   input  logic           upd_en,
   input  logic [IW-1:0]  upd_idx,
   input  logic [AW-1:0]  upd_ptr,
   input  logic           cfg_en,
   input  logic [IW-1:0]  cfg_idx,
   input  logic [1:0]     cfg_sel,
   input  logic [AW-1:0]  cfg_data,
   output logic [AW-1:0]  rd_ptr,
   output logic [AW-1:0]  rd_base,
   output logic [AW-1:0]  rd_len,
   output logic [BWW-1:0] rd_bw
);

   logic [AW-1:0]  ptr_a  [NCTX];
   logic [AW-1:0]  base_a [NCTX];
   logic [AW-1:0]  len_a  [NCTX];
   logic [BWW-1:0] bw_a   [NCTX];

   for (genvar g = 0; g < NCTX; g++) begin : g_ctx
      logic [AW-1:0]  p_q, b_q, l_q;
      logic [BWW-1:0] w_q;
      logic           hit_cfg, hit_upd;

      assign hit_cfg = cfg_en && (cfg_idx == IW'(g));
      assign hit_upd = upd_en && (upd_idx == IW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            p_q <= '0;
            b_q <= '0;
            l_q <= '0;
            w_q <= '0;
         end else begin
            if (hit_upd)
               p_q <= upd_ptr;
            else if (hit_cfg && cfg_sel == CF_PTR)
               p_q <= cfg_data;
            if (hit_cfg && cfg_sel == CF_BASE) b_q <= cfg_data;
            if (hit_cfg && cfg_sel == CF_LEN)  l_q <= cfg_data;
            if (hit_cfg && cfg_sel == CF_BW)   w_q <= cfg_data[BWW-1:0];
         end
      end

      assign ptr_a[g]  = p_q;
      assign base_a[g] = b_q;
      assign len_a[g]  = l_q;
      assign bw_a[g]   = w_q;
   end

   assign rd_ptr  = ptr_a[rd_idx];
   assign rd_base = base_a[rd_idx];
   assign rd_len  = len_a[rd_idx];
   assign rd_bw   = bw_a[rd_idx];

endmodule

// File: rtl/agu_step.sv
module agu_step
   import agu_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] mod,
   input  logic [1:0]    size,
   output logic [AW-1:0] step
);

   always_comb begin
      unique case (agu_size_e'(size))
         AS_SINGLE: step = mod;
         AS_DUAL:   step = {mod[AW-2:0], 1'b0};
         default:   step = {mod[AW-3:0], 2'b00};
      endcase
   end

endmodule

// File: rtl/agu_ring.sv
module agu_ring #(
   parameter int AW      = 32,
   parameter bit CIRC_EN = 1'b1
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] len,
   input  logic [AW-1:0] step,
   output logic [AW-1:0] nxt
);

   localparam int EW = AW + 2;

   logic signed [EW-1:0] s_sum;
   assign s_sum = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});

   if (CIRC_EN) begin : g_circ
      logic signed [EW-1:0] s_base, s_len, s_lim, s_fix;
      assign s_base = $signed({2'b00, base});
      assign s_len  = $signed({2'b00, len});
      assign s_lim  = s_base + s_len;

      always_comb begin
         if (len == '0)
            s_fix = s_sum;
         else if (s_sum >= s_lim)
            s_fix = s_sum - s_len;
         else if (s_sum < s_base)
            s_fix = s_sum + s_len;
         else
            s_fix = s_sum;
      end

      assign nxt = s_fix[AW-1:0];
   end else begin : g_lin
      logic unused_ok;
      assign unused_ok = ^{base, len, s_sum[EW-1:AW]};
      assign nxt = s_sum[AW-1:0];
   end

endmodule

// File: rtl/agu_brev.sv
module agu_brev #(
   parameter int AW  = 32,
   parameter int BWW = 6
) (
   input  logic [AW-1:0]  idx,
   input  logic [BWW-1:0] bw,
   input  logic [AW-1:0]  base,
   output logic [AW-1:0]  addr
);

   localparam logic [BWW:0] AWV = (BWW+1)'(AW);

   logic [AW-1:0]  rev_full, off;
   logic [BWW:0]   bw_eff, sh;

   always_comb begin
      for (int i = 0; i < AW; i++)
         rev_full[i] = idx[AW-1-i];
   end

   assign bw_eff = ({1'b0, bw} > AWV) ? AWV : {1'b0, bw};
   assign sh     = AWV - bw_eff;
   assign off    = (bw_eff == '0) ? '0 : (rev_full >> sh);
   assign addr   = base + off;

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
   import agu_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NCTX    = 4,
   parameter bit CIRC_EN = 1'b1,
   parameter bit BREV_EN = 1'b1,
   localparam int IW     = (NCTX > 1) ? $clog2(NCTX) : 1,
   localparam int BWW    = $clog2(AW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall,
   input  logic          req_valid,
   input  logic [IW-1:0] req_ctx,
   input  logic [1:0]    req_mode,
   input  logic          req_pre,
   input  logic [1:0]    req_size,
   input  logic [AW-1:0] req_mod,
   input  logic          cfg_we,
   input  logic [IW-1:0] cfg_ctx,
   input  logic [1:0]    cfg_sel,
   input  logic [AW-1:0] cfg_data,
   output logic          out_valid,
   output logic [AW-1:0] out_addr,
   output logic [AW-1:0] out_ptr
);

   initial begin
      assert (AW >= 8 && AW <= 64) else $error("AW out of range");
      assert (NCTX >= 2 && (1 << IW) == NCTX) else $error("NCTX must be a power of two >= 2");
   end

   logic            fire, cfg_en, upd_en;
   logic [AW-1:0]   ptr_rd, base_rd, len_rd, step, ring_nxt, lin_nxt;
   logic [BWW-1:0]  bw_rd;
   logic [AW-1:0]   brev_idx, brev_addr;
   logic [AW-1:0]   nxt_ptr, eff_addr;
   logic            do_upd;
   agu_mode_e       mode;

   assign fire   = req_valid && !stall;
   assign cfg_en = cfg_we && !stall;
   assign mode   = agu_mode_e'(req_mode);

   agu_ctx_file #(.AW(AW), .NCTX(NCTX), .IW(IW), .BWW(BWW)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (req_ctx),
      .upd_en   (upd_en),
      .upd_idx  (req_ctx),
      .upd_ptr  (nxt_ptr),
      .cfg_en   (cfg_en),
      .cfg_idx  (cfg_ctx),
      .cfg_sel  (cfg_sel),
      .cfg_data (cfg_data),
      .rd_ptr   (ptr_rd),
      .rd_base  (base_rd),
      .rd_len   (len_rd),
      .rd_bw    (bw_rd)
   );

   agu_step #(.AW(AW)) u_step (
      .mod  (req_mod),
      .size (req_size),
      .step (step)
   );

   agu_ring #(.AW(AW), .CIRC_EN(CIRC_EN)) u_ring (
      .ptr  (ptr_rd),
      .base (base_rd),
      .len  (len_rd),
      .step (step),
      .nxt  (ring_nxt)
   );

   assign lin_nxt  = ptr_rd + step;
   assign brev_idx = req_pre ? lin_nxt : ptr_rd;

   if (BREV_EN) begin : g_brev
      agu_brev #(.AW(AW), .BWW(BWW)) u_brev (
         .idx  (brev_idx),
         .bw   (bw_rd),
         .base (base_rd),
         .addr (brev_addr)
      );
   end else begin : g_nobrev
      logic unused_bw;
      assign unused_bw = ^bw_rd;
      assign brev_addr = brev_idx;
   end

   always_comb begin
      nxt_ptr  = ptr_rd;
      eff_addr = req_mod;
      do_upd   = 1'b0;
      unique case (mode)
         AM_IND: begin
            nxt_ptr  = ring_nxt;
            eff_addr = req_pre ? ring_nxt : ptr_rd;
            do_upd   = 1'b1;
         end
         AM_BREV: begin
            nxt_ptr  = lin_nxt;
            eff_addr = brev_addr;
            do_upd   = 1'b1;
         end
         default: begin
            nxt_ptr  = ptr_rd;
            eff_addr = req_mod;
            do_upd   = 1'b0;
         end
      endcase
   end

   assign upd_en = fire && do_upd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_ptr   <= '0;
      end else begin
         out_valid <= fire;
         if (fire) begin
            out_addr <= eff_addr;
            out_ptr  <= nxt_ptr;
         end
      end
   end

   // Helpers for the ring property: request inside the stated input contract.
   logic [AW-1:0] rel_pos, step_mag;
   logic [AW:0]   ring_end;
   logic          in_contract;
   assign rel_pos     = ptr_rd - base_rd;
   assign step_mag    = step[AW-1] ? (~step + 1'b1) : step;
   assign ring_end    = {1'b0, base_rd} + {1'b0, len_rd};
   assign in_contract = (ptr_rd >= base_rd) && (rel_pos < len_rd) &&
                        (step_mag <= len_rd) && !ring_end[AW];

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> out_valid); // R2
   AST_NO_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !out_valid); // R11
   AST_POST_OLD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode == AM_IND && !req_pre) |=> out_addr == $past(ptr_rd)); // R3
   AST_PRE_NEW_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode == AM_IND && req_pre) |=> out_addr == out_ptr); // R4
   AST_IMM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode == AM_IMM) |=> (out_ptr == $past(ptr_rd) && out_addr == $past(req_mod))); // R10
   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode == AM_IND && len_rd == '0) |=> out_ptr == $past(ptr_rd) + $past(step)); // R8
   AST_STAY_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode == AM_IND && len_rd != '0 && in_contract && CIRC_EN)
      |=> (out_ptr >= $past(base_rd) && (out_ptr - $past(base_rd)) < $past(len_rd))); // R6
   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_size != 2'd3); // R5
   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_mode != 2'd3); // R10

endmodule

// File: tb/circ_addr_gen_bench.sv
`timescale 1ns/1ps
module circ_addr_gen_bench;

   localparam int AW = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_ctx = '0;
   logic [1:0]  req_mode = '0;
   logic        req_pre = 1'b0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_mod = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_ctx = '0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_data = '0;
   logic        out_valid;
   logic [31:0] out_addr, out_ptr;

   always #2 clk = ~clk;

   circ_addr_gen u_circ_addr_gen (
      .clk(clk), .rst_n(rst_n), .stall(stall),
      .req_valid(req_valid), .req_ctx(req_ctx), .req_mode(req_mode),
      .req_pre(req_pre), .req_size(req_size), .req_mod(req_mod),
      .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .out_valid(out_valid), .out_addr(out_addr), .out_ptr(out_ptr)
   );

   typedef struct {
      logic [31:0] addr;
      logic [31:0] ptr;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   exp_t        cur;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   logic [31:0] m_ptr [4];
   logic [31:0] m_base [4];
   logic [31:0] m_len [4];
   int          m_bw [4];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rev_bits(input logic [31:0] v, input int w);
      logic [31:0] r = '0;
      for (int k = 0; k < w; k++) r[k] = v[w-1-k];
      return r;
   endfunction

   task automatic idle();
      @(posedge clk); #1;
      req_valid = 1'b0; cfg_we = 1'b0; stall = 1'b0;
   endtask

   task automatic cfg(input int c, input int sel, input logic [31:0] d);
      @(posedge clk); #1;
      req_valid = 1'b0; cfg_we = 1'b1;
      cfg_ctx = 2'(c); cfg_sel = 2'(sel); cfg_data = d;
      case (sel)
         0: m_ptr[c] = d;
         1: m_base[c] = d;
         2: m_len[c] = d;
         default: m_bw[c] = int'(d[5:0]);
      endcase
   endtask

   // Scoreboard driver: computes the expected result from the requirements.
   task automatic req(input int c, input int mode, input bit pre, input int size,
                      input logic [31:0] mod, input string tag);
      logic [31:0] stp, np, ea, idx;
      longint      s;
      stp = mod << ((size == 0) ? 0 : (size == 1) ? 1 : 2);
      np  = m_ptr[c];
      ea  = mod;
      if (mode == 1) begin
         if (m_len[c] == 0) np = m_ptr[c] + stp;
         else begin
            s = longint'(m_ptr[c]) + longint'($signed(stp));
            if (s >= longint'(m_base[c]) + longint'(m_len[c])) s = s - longint'(m_len[c]);
            else if (s < longint'(m_base[c])) s = s + longint'(m_len[c]);
            np = s[31:0];
         end
         ea = pre ? np : m_ptr[c];
      end else if (mode == 2) begin
         np  = m_ptr[c] + stp;
         idx = pre ? np : m_ptr[c];
         ea  = m_base[c] + rev_bits(idx, m_bw[c]);
      end
      sb.push_back('{addr: ea, ptr: np, tag: tag});
      m_ptr[c] = np;
      @(posedge clk); #1;
      cfg_we = 1'b0; req_valid = 1'b1;
      req_ctx = 2'(c); req_mode = 2'(mode); req_pre = pre;
      req_size = 2'(size); req_mod = mod;
   endtask

   // Monitor: pops expected items as results appear.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R2", "unexpected result", out_addr, 32'h0);
         end else begin
            cur = sb.pop_front();
            chk(out_addr == cur.addr, cur.tag, "address", out_addr, cur.addr);
            chk(out_ptr == cur.ptr, cur.tag, "pointer", out_ptr, cur.ptr);
         end
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_ptr[i] = '0; m_base[i] = '0; m_len[i] = '0; m_bw[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "valid after reset", 32'(out_valid), 32'h0);

      // R1: zeroed context yields zero pointer
      req(0, 1, 1'b0, 0, 32'd0, "R1");
      idle();

      // Ring at unaligned start 100, length 10
      cfg(0, 1, 32'd100);
      cfg(0, 2, 32'd10);
      cfg(0, 0, 32'd100);
      req(0, 1, 1'b0, 0, 32'd3, "R3");
      req(0, 1, 1'b0, 0, 32'd4, "R2");
      req(0, 1, 1'b0, 0, 32'd5, "R6");
      req(0, 1, 1'b1, 0, -32'sd4, "R7");
      req(0, 1, 1'b1, 1, 32'd1, "R5");
      req(0, 1, 1'b0, 2, 32'd2, "R5");
      req(0, 1, 1'b1, 0, 32'd10, "R6");
      req(0, 1, 1'b1, 0, -32'sd10, "R7");
      req(0, 1, 1'b1, 0, 32'd2, "R4");
      idle();

      // R8: length zero steps linearly and wraps modulo 2^32
      cfg(1, 0, 32'd50);
      req(1, 1, 1'b1, 0, -32'sd60, "R8");
      req(1, 1, 1'b0, 1, 32'd8, "R8");
      idle();

      // R9: bit-reverse, width 3, start 0x1000
      cfg(2, 1, 32'h1000);
      cfg(2, 3, 32'd3);
      cfg(2, 0, 32'd0);
      for (int i = 0; i < 8; i++) req(2, 2, 1'b0, 0, 32'd1, "R9");
      req(2, 2, 1'b1, 0, 32'd1, "R9");
      req(2, 2, 1'b1, 1, 32'd1, "R9");
      idle();

      // R10: immediate passes the modifier, pointer untouched
      req(0, 0, 1'b0, 2, 32'h1234, "R10");
      req(0, 1, 1'b0, 0, 32'd0, "R10");
      idle();

      // R11: stall blocks request and configuration write
      @(posedge clk); #1;
      stall = 1'b1; req_valid = 1'b1; req_ctx = 2'd0; req_mode = 2'd1;
      req_pre = 1'b0; req_size = 2'd0; req_mod = 32'd5;
      cfg_we = 1'b1; cfg_ctx = 2'd0; cfg_sel = 2'd0; cfg_data = 32'd0;
      @(posedge clk); #1;
      stall = 1'b0; req_valid = 1'b0; cfg_we = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R11", "valid during stall", 32'(out_valid), 32'h0);
      req(0, 1, 1'b0, 0, 32'd0, "R11");
      idle();

      // R12: programming another context leaves context 0 alone
      cfg(3, 1, 32'd7);
      cfg(3, 2, 32'd3);
      cfg(3, 0, 32'd8);
      req(3, 1, 1'b1, 0, 32'd2, "R12");
      req(0, 1, 1'b0, 0, 32'd0, "R12");
      idle();

      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R2", "results outstanding", 32'(sb.size()), 32'h0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R2 watchdog: actual=%0h expected=%0h", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule